// File: doc/BRIEF.md
# Key-Sequence Protected Configuration Lock

This block guards a bank of pin-remapping selection registers against stray writes. A lock flag sits in its own register on a simple byte-wide bus. The flag can change only on the bus access that comes right after a two-byte unlock key has been written to that register. While the flag is set, the block holds down the write-enable to the selection bank, so the bank keeps its contents. While the flag is clear, writes reach the bank.

A static one-way configuration input allows the flag to be set only once per reset. Once it is set in that mode, it cannot be cleared until the next reset. Two reset inputs are provided. The power-on reset returns everything to its default values. The warm reset clears only the lock flag and the key tracker, and leaves the selection contents as they were. Software reads back the lock register and each selection register on the same bus.

Top module: `keyed_cfg_lock`

## Requirements
- R1: After power-on reset, `locked` is 0 and selection register i reads back (i+1) truncated to SEL_W bits.
- R2: A byte write of 0x55 and then a byte write of 0xAA to the lock address arm the block. A bit-set (bit 0) on the lock address as the next access sets the flag. A bit-clear (bit 0) on the lock address as the next access clears it.
- R3: Any other bus write placed between the 0x55 and the 0xAA cancels the key, so a following bit operation has no effect on the flag.
- R4: A 0x55 written while the block waits for 0xAA restarts the key. A following 0xAA then arms the block.
- R5: A flag change is taken only on the first bus access after the key. Idle cycles in between are allowed. A bit operation without a key, or one after an intervening write, is ignored.
- R6: Byte writes to the lock address never change the flag, even when the block is armed.
- R7: While the flag is set, `sel_we` stays low and selection registers keep their values. While it is clear, writes and bit operations to selection addresses update them with `sel_we` high.
- R8: With `one_way_cfg` high, once the flag has been set, a keyed clear is ignored until the next reset.
- R9: Warm reset clears the flag and the one-way state and leaves selection contents unchanged. Power-on reset restores the selection defaults.
- R10: Reading the lock address returns the flag in bit 0 and zero in bits 7:1. Key bytes are never read back.
- R11: A bit operation on the lock address with a bit index other than 0 does not change the flag.
- R12: A bit set or bit clear on a selection address changes only the indexed bit of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| warm_n | input | 1 | Synchronous active-low warm reset |
| one_way_cfg | input | 1 | Static one-way lock mode |
| bus_wr | input | 1 | Byte write strobe |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_addr | input | ADDR_W | Register address; selection registers at 0..NUM_SEL-1, lock register at NUM_SEL |
| bus_wdata | input | 8 | Byte write data |
| bus_bidx | input | 3 | Bit index for bit operations |
| bus_rdata | output | 8 | Read data for bus_addr |
| sel_we | output | 1 | Gated write-enable to the selection bank |
| locked | output | 1 | Current lock flag |
| sel_flat | output | NUM_SEL*SEL_W | Selection register contents, register i at bits i*SEL_W upward |

## Verification
The bench builds the block with its defaults: six selection registers of six bits each, a four-bit address, and the lock register at address 6. With six-bit registers, byte writes must be truncated, and bit indices both inside and outside a register can be used. The bench also places one selection address at the top of the register range, next to the lock address, to cover the address decode at that boundary. With six registers, the bench can show that a write to one register leaves the others untouched, and that warm and power-on resets treat the stored values differently.

// File: rtl/keyed_lock_pkg.sv
// Shared types and constants for the keyed configuration lock.
// Assumes a byte-wide bus; the key values are fixed by the lock behaviour.
package keyed_lock_pkg;
    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/keyed_lock_seq.sv
// Key tracker: watches bus writes for the two-byte unlock key on the lock
// address and reports "armed" until the next bus access consumes it.
// Assumes wr_byte and wr_bit are never high together.
module keyed_lock_seq
    import keyed_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_byte,
    input  logic       wr_bit,
    input  logic       hit_lock,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_state_e state_q, state_d;

    // Next key state: only bus accesses move the tracker.
    always_comb begin
        state_d = state_q;
        if (wr_byte || wr_bit) begin
            if (wr_byte && hit_lock && wdata == KEY_FIRST)
                state_d = KEY_HALF;
            else if (wr_byte && hit_lock && wdata == KEY_SECOND && state_q == KEY_HALF)
                state_d = KEY_ARMED;
            else
                state_d = KEY_IDLE;
        end
    end

    // State register, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == KEY_ARMED);

    // R2: a second key byte right after the first arms the tracker.
    assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_HALF && wr_byte && hit_lock && wdata == KEY_SECOND) |=> armed);

    // R5: a bit operation always uses up the armed state.
    assert_arm_single_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_bit) |=> !armed);
endmodule

// File: rtl/keyed_lock_state.sv
// Lock flag and one-way seal. The flag moves only on a keyed bit operation;
// in one-way mode a keyed set seals the flag until the next reset.
// Assumes op_set/op_clr already decode the lock address and bit 0.
module keyed_lock_state (
    input  logic clk,
    input  logic rst_n,
    input  logic one_way,
    input  logic armed,
    input  logic op_set,
    input  logic op_clr,
    output logic locked
);
    logic locked_q;
    logic sealed_q;
    logic take_set;
    logic take_clr;

    // Accept decisions for the current access.
    always_comb begin
        take_set = armed && op_set;
        take_clr = armed && op_clr && !(one_way && sealed_q);
    end

    // Lock flag and seal registers, both cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            sealed_q <= 1'b0;
        end else begin
            if (take_set)      locked_q <= 1'b1;
            else if (take_clr) locked_q <= 1'b0;
            if (take_set && one_way) sealed_q <= 1'b1;
        end
    end

    assign locked = locked_q;

    // R5: without a keyed bit operation the flag does not move.
    assert_flag_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && (op_set || op_clr)) |=> $stable(locked_q));

    // R8: a sealed one-way lock stays set.
    assert_seal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed_q && one_way) |=> locked_q);
endmodule

// File: rtl/keyed_lock_bank.sv
// Selection register bank with write gating. Byte writes load the low SEL_W
// bits; bit operations change one indexed bit. Only power-on reset restores
// the defaults (register i defaults to i+1).
module keyed_lock_bank #(
    parameter int NUM_SEL = 6,
    parameter int SEL_W   = 6,
    localparam int IDX_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       locked,
    input  logic                       hit_sel,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wr_byte,
    input  logic                       wr_bit,
    input  logic                       bit_val,
    input  logic [2:0]                 bidx,
    input  logic [SEL_W-1:0]           wdata,
    output logic                       we,
    output logic [NUM_SEL*SEL_W-1:0]   sel_flat
);
    logic [SEL_W-1:0] bit_mask;

    // Gated enable and single-bit mask for bit operations.
    always_comb begin
        we       = hit_sel && (wr_byte || wr_bit) && !locked;
        bit_mask = SEL_W'(1) << bidx;
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        localparam logic [SEL_W-1:0] DEF = SEL_W'(i + 1);
        logic [SEL_W-1:0] reg_q;

        // One selection register: power-on default, else gated update.
        always_ff @(posedge clk) begin
            if (!por_n) begin
                reg_q <= DEF;
            end else if (we && idx == IDX_W'(i)) begin
                if (wr_byte)      reg_q <= wdata;
                else if (bit_val) reg_q <= reg_q | bit_mask;
                else              reg_q <= reg_q & ~bit_mask;
            end
        end

        assign sel_flat[i*SEL_W +: SEL_W] = reg_q;
    end

    // R7: while locked the bank does not change.
    assert_locked_blocks_R7: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> $stable(sel_flat));
endmodule

// File: rtl/keyed_cfg_lock.sv
// Top of the keyed configuration lock: decodes the bus, feeds the key
// tracker and lock flag, gates the selection bank, and muxes read data.
// Assumes byte write and bit strobes are not issued together (byte wins).
// Address map: selection registers 0..NUM_SEL-1, lock register at NUM_SEL.
module keyed_cfg_lock #(
    parameter int ADDR_W  = 4,
    parameter int NUM_SEL = 6,
    parameter int SEL_W   = 6
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     warm_n,
    input  logic                     one_way_cfg,
    input  logic                     bus_wr,
    input  logic                     bus_bset,
    input  logic                     bus_bclr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [7:0]               bus_wdata,
    input  logic [2:0]               bus_bidx,
    output logic [7:0]               bus_rdata,
    output logic                     sel_we,
    output logic                     locked,
    output logic [NUM_SEL*SEL_W-1:0] sel_flat
);
    localparam int IDX_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_SEL);

    logic rst_lock_n;
    logic wr_bit;
    logic hit_lock;
    logic hit_sel;
    logic armed;
    logic op_set;
    logic op_clr;

    // Bus decode shared by the sub-blocks.
    always_comb begin
        rst_lock_n = por_n && warm_n;
        wr_bit     = (bus_bset || bus_bclr) && !bus_wr;
        hit_lock   = (bus_addr == LOCK_ADDR);
        hit_sel    = (bus_addr < LOCK_ADDR);
        op_set     = wr_bit && bus_bset && hit_lock && bus_bidx == 3'd0;
        op_clr     = wr_bit && !bus_bset && hit_lock && bus_bidx == 3'd0;
    end

    keyed_lock_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_lock_n),
        .wr_byte  (bus_wr),
        .wr_bit   (wr_bit),
        .hit_lock (hit_lock),
        .wdata    (bus_wdata),
        .armed    (armed)
    );

    keyed_lock_state u_state (
        .clk     (clk),
        .rst_n   (rst_lock_n),
        .one_way (one_way_cfg),
        .armed   (armed),
        .op_set  (op_set),
        .op_clr  (op_clr),
        .locked  (locked)
    );

    keyed_lock_bank #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .por_n    (por_n),
        .locked   (locked),
        .hit_sel  (hit_sel),
        .idx      (bus_addr[IDX_W-1:0]),
        .wr_byte  (bus_wr),
        .wr_bit   (wr_bit),
        .bit_val  (bus_bset),
        .bidx     (bus_bidx),
        .wdata    (bus_wdata[SEL_W-1:0]),
        .we       (sel_we),
        .sel_flat (sel_flat)
    );

    // Read mux: lock flag in bit 0 or a zero-extended selection register.
    always_comb begin
        bus_rdata = 8'h00;
        if (hit_lock) bus_rdata[0] = locked;
        for (int i = 0; i < NUM_SEL; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = 8'(sel_flat[i*SEL_W +: SEL_W]);
    end

    // R9: a warm reset with no bus activity leaves the selection bank alone.
    assert_warm_keeps_sel_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_n && !bus_wr && !bus_bset && !bus_bclr) |=> $stable(sel_flat));
endmodule

// File: tb/keyed_cfg_lock_bench.sv
// Directed bench for keyed_cfg_lock: one task per scenario.
module keyed_cfg_lock_bench;
    localparam int ADDR_W  = 4;
    localparam int NUM_SEL = 6;
    localparam int SEL_W   = 6;
    localparam logic [ADDR_W-1:0] LK = ADDR_W'(NUM_SEL);

    logic                     clk = 1'b0;
    logic                     por_n = 1'b0, warm_n = 1'b1, one_way_cfg = 1'b0;
    logic                     bus_wr = 1'b0, bus_bset = 1'b0, bus_bclr = 1'b0;
    logic [ADDR_W-1:0]        bus_addr = '0;
    logic [7:0]               bus_wdata = '0;
    logic [2:0]               bus_bidx = '0;
    logic [7:0]               bus_rdata;
    logic                     sel_we, locked;
    logic [NUM_SEL*SEL_W-1:0] sel_flat;

    int  checks = 0, errors = 0;
    bit  done = 0;
    logic last_we;

    keyed_cfg_lock #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_keyed_cfg_lock (
        .clk(clk), .por_n(por_n), .warm_n(warm_n), .one_way_cfg(one_way_cfg),
        .bus_wr(bus_wr), .bus_bset(bus_bset), .bus_bclr(bus_bclr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_bidx(bus_bidx),
        .bus_rdata(bus_rdata), .sel_we(sel_we), .locked(locked), .sel_flat(sel_flat)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // All bus tasks start just after a falling edge and end on one.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 last_we = sel_we;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bop(input logic [ADDR_W-1:0] a, input logic [2:0] b, input logic set);
        bus_addr = a; bus_bidx = b; bus_bset = set; bus_bclr = !set;
        #1 last_we = sel_we;
        @(negedge clk); bus_bset = 1'b0; bus_bclr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output int v);
        bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic key();
        wr(LK, 8'h55); wr(LK, 8'hAA);
    endtask

    task automatic do_por();
        por_n = 1'b0; repeat (2) @(negedge clk); por_n = 1'b1;
    endtask

    task automatic do_warm();
        warm_n = 1'b0; repeat (2) @(negedge clk); warm_n = 1'b1;
    endtask

    task automatic t_reset();
        int v;
        chk("R1 locked after por", locked, 0);
        for (int i = 0; i < NUM_SEL; i++) begin
            rd(ADDR_W'(i), v);
            chk($sformatf("R1 default sel%0d", i), v, (i + 1) & 63);
        end
        rd(LK, v); chk("R10 lock read after por", v, 0);
    endtask

    task automatic t_lock_unlock();
        int v;
        key(); bop(LK, 0, 1);
        chk("R2 keyed set", locked, 1);
        rd(LK, v); chk("R10 lock read locked", v, 1);
        wr(0, 8'h3F);
        chk("R7 sel_we low when locked", last_we, 0);
        rd(0, v); chk("R7 sel0 unchanged when locked", v, 1);
        bop(3, 0, 1); rd(3, v); chk("R7 bit op blocked when locked", v, 4);
        key(); bop(LK, 0, 0);
        chk("R2 keyed clear", locked, 0);
        wr(0, 8'hD5);
        chk("R7 sel_we high when unlocked", last_we, 1);
        rd(0, v); chk("R7 sel0 written, truncated", v, 8'h15);
    endtask

    task automatic t_abort();
        int v;
        wr(LK, 8'h55); wr(1, 8'h07); wr(LK, 8'hAA); bop(LK, 0, 1);
        chk("R3 write between key bytes aborts", locked, 0);
        rd(1, v); chk("R3 intervening write landed", v, 7);
        wr(LK, 8'h55); bop(2, 0, 1); wr(LK, 8'hAA); bop(LK, 0, 1);
        chk("R3 bit op between key bytes aborts", locked, 0);
    endtask

    task automatic t_restart();
        wr(LK, 8'h55); wr(LK, 8'h55); wr(LK, 8'hAA); bop(LK, 0, 1);
        chk("R4 repeated 55 restarts key", locked, 1);
        key(); bop(LK, 0, 0);
        chk("R4 unlock after restart test", locked, 0);
    endtask

    task automatic t_immediate();
        key(); wr(2, 8'h09); bop(LK, 0, 1);
        chk("R5 write after key consumes it", locked, 0);
        bop(LK, 0, 1);
        chk("R5 bit op without key ignored", locked, 0);
        key(); repeat (3) @(negedge clk); bop(LK, 0, 1);
        chk("R5 idle cycles keep key armed", locked, 1);
        key(); bop(LK, 0, 0); bop(LK, 0, 1);
        chk("R5 second op after key ignored", locked, 0);
    endtask

    task automatic t_byte_lock();
        int v;
        key(); wr(LK, 8'h01);
        chk("R6 byte write does not set flag", locked, 0);
        wr(LK, 8'h55); rd(LK, v);
        chk("R10 key byte not read back", v, 0);
        wr(LK, 8'hAA); rd(LK, v);
        chk("R10 second key byte not read back", v, 0);
    endtask

    task automatic t_bidx();
        int v;
        key(); bop(LK, 1, 1);
        chk("R11 bit index 1 ignored", locked, 0);
        key(); bop(LK, 7, 1); rd(LK, v);
        chk("R11 bit index 7 ignored", v, 0);
    endtask

    task automatic t_bitop_sel();
        int v;
        bop(3, 0, 1); rd(3, v); chk("R12 bit set on sel3", v, 5);
        chk("R12 sel_we high on bit op", last_we, 1);
        bop(3, 2, 0); rd(3, v); chk("R12 bit clear on sel3", v, 1);
        rd(4, v); chk("R12 neighbour sel4 untouched", v, 5);
        bop(5, 6, 1); rd(5, v); chk("R12 index beyond width no change", v, 6);
    endtask

    task automatic t_one_way();
        int v;
        one_way_cfg = 1'b1; do_por();
        wr(5, 8'h2A);
        key(); bop(LK, 0, 1);
        chk("R8 one-way set", locked, 1);
        key(); bop(LK, 0, 0);
        chk("R8 one-way clear refused", locked, 1);
        do_warm();
        chk("R9 warm reset unlocks", locked, 0);
        rd(5, v); chk("R9 warm reset keeps sel5", v, 8'h2A);
        key(); bop(LK, 0, 1); key(); bop(LK, 0, 0);
        chk("R8 seal re-armed after warm reset", locked, 1);
        one_way_cfg = 1'b0; do_por();
        chk("R9 por unlocks", locked, 0);
        rd(5, v); chk("R9 por restores sel5", v, 6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); por_n = 1'b1;
        t_reset();
        t_lock_unlock();
        t_abort();
        t_restart();
        t_immediate();
        t_byte_lock();
        t_bidx();
        t_bitop_sel();
        t_one_way();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule